// File: doc/BRIEF.md
# Sampling ADC Conversion Sequencer

This block sits on the host side of a 12-bit sampling converter with a parallel result bus and no pipeline latency. When a trigger request arrives and the previous conversion has had its acquisition gap, the sequencer pulls the active-low select line, waits a setup interval, and then drives an active-low start strobe for a fixed low time. It then waits for the converter's status line (high when idle, low while converting) to return high. That status line is brought into the clock domain through a two-flop synchronizer. The rising edge of the synchronized status is the data-ready strobe, and the sequencer captures the 12-bit two's complement word one clock after it sees that edge.

Each captured word leaves on a one-cycle valid pulse, together with a wrapping sample counter. A trigger that arrives while a conversion or acquisition gap is in progress is rejected and counted. If the status line does not return high within a set number of cycles, a sticky timeout flag is raised and the sequencer recovers on its own. All timing minimums are parameters in whole clock cycles, each rounded up from the converter's nanosecond limits.

The result output has no ready input. The converter cannot be paused and holds no queue, so the consumer must take every word in the cycle its valid pulse is high. Back-pressure is not supported.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, adc_sel_n and adc_start_n are 1, smp_valid and timeout_err are 0, and smp_count and drop_count are 0.
- R2: An accepted trigger drives adc_sel_n low at least SETUP_CYC cycles before adc_start_n falls.
- R3: adc_start_n stays low for exactly LOW_CYC cycles per conversion, and only while adc_sel_n is low.
- R4: A trigger_req seen while the sequencer is not idle starts no conversion and increments drop_count by one.
- R5: smp_valid is a single-cycle pulse, and smp_data equals the adc_word present when adc_idle returned high.
- R6: smp_valid is high in the cycle after the fourth rising clock edge that follows adc_idle rising (two synchronizer flops, edge detect, capture).
- R7: A new falling edge on adc_start_n comes at least ACQ_CYC cycles after adc_idle rose for the previous conversion, and adc_start_n is then high for at least HIGH_CYC cycles.
- R8: If adc_idle has not risen TIMEOUT_CYC cycles after adc_start_n returns high, timeout_err sets at that edge, stays set until reset, no sample is produced, adc_sel_n is released, and later triggers are again served.
- R9: smp_count increments by one, modulo 2^SCNT_W, with each smp_valid pulse.
- R10: smp_data keeps the two's complement word unchanged, with bit 11 as the sign/MSB and bit 0 as the LSB (0x800 is the most negative value, 0x7FF the most positive).
- R11: adc_sel_n stays low from trigger acceptance until adc_idle has returned high, and it is high in the cycle smp_valid is high.
- R12: A rise of adc_idle while no conversion is outstanding produces no smp_valid and leaves smp_count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_req | input | 1 | Conversion request, sampled each clock |
| adc_sel_n | output | 1 | Active-low converter select |
| adc_start_n | output | 1 | Active-low convert start strobe |
| adc_idle | input | 1 | Converter status, low while converting |
| adc_word | input | DATA_W | Parallel result bus from converter |
| smp_valid | output | 1 | One-cycle result strobe |
| smp_data | output | DATA_W | Captured two's complement result |
| smp_count | output | SCNT_W | Wrapping count of captured samples |
| drop_count | output | DCNT_W | Wrapping count of rejected triggers |
| timeout_err | output | 1 | Sticky conversion timeout flag |

## Verification
A trigger sampled at edge E0 drops the select line at E0, the start strobe falls at E0+SETUP_CYC and rises LOW_CYC edges later. The sample appears four edges after the status line rises, and a missing status rise sets the timeout flag exactly TIMEOUT_CYC edges after the start strobe rises. The bench samples every output at the falling clock edge and keeps a falling-edge counter. It records the counter value at each status rise, start-strobe edge and select fall, and compares each later event against those stamps using the exact latencies above. Each expected word is queued at trigger time, and the monitor pops one entry per valid pulse.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_WAIT,
    ST_CAPT,
    ST_ACQ
  } seq_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/busy_sync.sv
module busy_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise_o = s2 & ~s3;

  // R6: the edge strobe lasts one cycle
  a_r6_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= load_val - 1'b1;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sample_capture.sv
module sample_capture #(
  parameter int DW = 12,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic [CW-1:0] count_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      count_o <= '0;
    end else begin
      valid_o <= capture;
      if (capture) begin
        data_o  <= bus_in;
        count_o <= count_o + 1'b1;
      end
    end
  end

  // R5: result strobe is one cycle wide
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R9: counter steps with each strobe
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> count_o == $past(count_o) + 1'b1);
endmodule

// File: rtl/event_counter.sv
module event_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (inc)
      count <= count + 1'b1;
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SETUP_CYC   = 1,
  parameter int LOW_CYC     = 3,
  parameter int HIGH_CYC    = 3,
  parameter int ACQ_CYC     = 7,
  parameter int TIMEOUT_CYC = 48,
  parameter int SCNT_W      = 8,
  parameter int DCNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_req,
  output logic              adc_sel_n,
  output logic              adc_start_n,
  input  logic              adc_idle,
  input  logic [DATA_W-1:0] adc_word,
  output logic              smp_valid,
  output logic [DATA_W-1:0] smp_data,
  output logic [SCNT_W-1:0] smp_count,
  output logic [DCNT_W-1:0] drop_count,
  output logic              timeout_err
);
  localparam int GAP_CYC = imax(ACQ_CYC, HIGH_CYC);
  localparam int T_MAX   = imax(imax(SETUP_CYC, LOW_CYC), imax(GAP_CYC, TIMEOUT_CYC));
  localparam int TW      = $clog2(T_MAX + 1);

  seq_state_t st, nxt;
  logic          t_load, t_exp, idle_rise, do_capture, to_hit, trig_drop;
  logic [TW-1:0] t_val;

  busy_sync u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(adc_idle), .rise_o(idle_rise)
  );

  phase_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  sample_capture #(.DW(DATA_W), .CW(SCNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .capture(do_capture), .bus_in(adc_word),
    .data_o(smp_data), .valid_o(smp_valid), .count_o(smp_count)
  );

  event_counter #(.W(DCNT_W)) u_drops (
    .clk(clk), .rst_n(rst_n), .inc(trig_drop), .count(drop_count)
  );

  assign trig_drop = trig_req && (st != ST_IDLE);

  always_comb begin
    nxt        = st;
    t_load     = 1'b0;
    t_val      = TW'(SETUP_CYC);
    do_capture = 1'b0;
    to_hit     = 1'b0;
    unique case (st)
      ST_IDLE: if (trig_req) begin
        nxt = ST_SETUP; t_load = 1'b1; t_val = TW'(SETUP_CYC);
      end
      ST_SETUP: if (t_exp) begin
        nxt = ST_LOW; t_load = 1'b1; t_val = TW'(LOW_CYC);
      end
      ST_LOW: if (t_exp) begin
        nxt = ST_WAIT; t_load = 1'b1; t_val = TW'(TIMEOUT_CYC);
      end
      ST_WAIT: begin
        if (idle_rise) begin
          nxt = ST_CAPT;
        end else if (t_exp) begin
          to_hit = 1'b1;
          nxt = ST_ACQ; t_load = 1'b1; t_val = TW'(GAP_CYC);
        end
      end
      ST_CAPT: begin
        do_capture = 1'b1;
        nxt = ST_ACQ; t_load = 1'b1; t_val = TW'(GAP_CYC);
      end
      ST_ACQ: if (t_exp) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      adc_sel_n   <= 1'b1;
      adc_start_n <= 1'b1;
      timeout_err <= 1'b0;
    end else begin
      st          <= nxt;
      adc_sel_n   <= !(nxt inside {ST_SETUP, ST_LOW, ST_WAIT, ST_CAPT});
      adc_start_n <= !(nxt == ST_LOW);
      if (to_hit) timeout_err <= 1'b1;
    end
  end

  // R2: select already low in the cycle before start falls
  a_r2_select_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_start_n) |-> $past(!adc_sel_n));
  // R3: start only asserted under select
  a_r3_start_under_select: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_start_n |-> !adc_sel_n);
  // R4: a busy-time request is counted
  a_r4_drop_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_req && st != ST_IDLE) |=> drop_count != $past(drop_count));
  // R8: timeout flag is sticky
  a_r8_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);
  // R11: select released when the sample is presented
  a_r11_release_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> adc_sel_n);
endmodule

// File: tb/test_adc_conv_seq.sv
module test_adc_conv_seq;
  localparam int SETUP_CYC = 1, LOW_CYC = 3, HIGH_CYC = 3, ACQ_CYC = 7, TIMEOUT_CYC = 48;
  localparam int CONV_CYC = 30;

  logic clk = 1'b0, rst_n = 1'b0, trig_req = 1'b0, adc_idle = 1'b1;
  logic [11:0] adc_word = '0;
  logic adc_sel_n, adc_start_n, smp_valid, timeout_err;
  logic [11:0] smp_data;
  logic [7:0]  smp_count, drop_count;

  int n_checks = 0, n_fail = 0;
  int ncyc = 0, rise_at = -1000, sel_fall_at = 0, start_fall_at = 0, start_rise_at = 0, to_rise_at = 0;
  int conv_left = 0, conversions = 0, valids = 0;
  logic hang = 1'b0, prev_start = 1'b1, prev_sel = 1'b1, prev_to = 1'b0, done = 1'b0;
  logic [11:0] model_val = '0;
  logic [7:0]  exp_count = '0;
  logic [11:0] exp_q[$];

  always #4 clk = ~clk;

  adc_conv_seq i_adc_conv_seq (
    .clk(clk), .rst_n(rst_n), .trig_req(trig_req), .adc_sel_n(adc_sel_n),
    .adc_start_n(adc_start_n), .adc_idle(adc_idle), .adc_word(adc_word),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_count(smp_count),
    .drop_count(drop_count), .timeout_err(timeout_err)
  );

  task automatic check(input string req, input logic ok, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, ncyc);
    end
  endtask

  // monitor and converter model, both on the falling edge
  initial forever begin
    @(negedge clk);
    ncyc++;
    if (!rst_n) begin
      prev_start = 1'b1; prev_sel = 1'b1; prev_to = 1'b0;
    end else begin
      if (prev_sel && !adc_sel_n) sel_fall_at = ncyc;
      if (prev_start && !adc_start_n) begin
        start_fall_at = ncyc;
        check("R2 setup", (ncyc - sel_fall_at) >= SETUP_CYC, ncyc - sel_fall_at, SETUP_CYC);
        check("R7 acquisition gap", (ncyc - rise_at) >= ACQ_CYC, ncyc - rise_at, ACQ_CYC);
        check("R7 high time", (ncyc - start_rise_at) >= HIGH_CYC, ncyc - start_rise_at, HIGH_CYC);
        check("R3 start under select", !adc_sel_n, adc_sel_n, 0);
      end
      if (!prev_start && adc_start_n) begin
        start_rise_at = ncyc;
        check("R3 low time", (ncyc - start_fall_at) == LOW_CYC, ncyc - start_fall_at, LOW_CYC);
      end
      if (!prev_to && timeout_err) to_rise_at = ncyc;
      if (smp_valid) begin
        valids++;
        exp_count = exp_count + 1'b1;
        check("R6 latency", ncyc == rise_at + 4, ncyc - rise_at, 4);
        check("R11 select released", adc_sel_n, adc_sel_n, 1);
        check("R9 count", smp_count == exp_count, smp_count, exp_count);
        if (exp_q.size() == 0) begin
          check("R12 unexpected sample", 1'b0, smp_data, -1);
        end else begin
          logic [11:0] e;
          e = exp_q.pop_front();
          check("R5/R10 data", smp_data == e, smp_data, e);
        end
      end
      prev_start = adc_start_n; prev_sel = adc_sel_n; prev_to = timeout_err;
      // converter model
      if (conv_left > 0) begin
        conv_left--;
        if (conv_left == 0) begin
          check("R11 select held", !adc_sel_n, adc_sel_n, 0);
          adc_word = model_val;
          adc_idle = 1'b1;
          rise_at = ncyc;
        end
      end else if (!adc_start_n && adc_idle && !adc_sel_n && start_fall_at == ncyc) begin
        adc_idle = 1'b0;
        adc_word = 12'h3C3;
        conversions++;
        if (!hang) conv_left = CONV_CYC;
      end
    end
  end

  task automatic pulse_trig();
    @(negedge clk); trig_req = 1'b1;
    @(negedge clk); trig_req = 1'b0;
  endtask

  task automatic convert_one(input logic [11:0] v);
    model_val = v;
    exp_q.push_back(v);
    pulse_trig();
    repeat (60) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sel", adc_sel_n == 1'b1, adc_sel_n, 1);
    check("R1 start", adc_start_n == 1'b1, adc_start_n, 1);
    check("R1 valid", smp_valid == 1'b0, smp_valid, 0);
    check("R1 timeout", timeout_err == 1'b0, timeout_err, 0);
    check("R1 counts", smp_count == 0 && drop_count == 0, smp_count + drop_count, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 sign and magnitude extremes, R5 data
    convert_one(12'h000);
    convert_one(12'h7FF);
    convert_one(12'h800);
    convert_one(12'hFFF);
    convert_one(12'h5A3);
    check("R5 sample total", valids == 5, valids, 5);

    // R4 trigger during conversion is dropped
    begin
      int c0, d0;
      c0 = conversions; d0 = drop_count;
      model_val = 12'h123; exp_q.push_back(12'h123);
      pulse_trig();
      repeat (10) @(negedge clk);
      pulse_trig();
      @(negedge clk);
      check("R4 drop count", drop_count == d0 + 1, drop_count, d0 + 1);
      repeat (60) @(negedge clk);
      check("R4 no extra conversion", conversions == c0 + 1, conversions, c0 + 1);
    end

    // R12 stray status rise while idle
    begin
      int v0;
      v0 = valids;
      adc_idle = 1'b0;
      repeat (5) @(negedge clk);
      adc_idle = 1'b1;
      repeat (12) @(negedge clk);
      check("R12 no sample", valids == v0, valids, v0);
      check("R12 count kept", smp_count == exp_count, smp_count, exp_count);
    end

    // R8 timeout
    check("R8 clear before", timeout_err == 1'b0, timeout_err, 0);
    hang = 1'b1;
    begin
      int v0;
      v0 = valids;
      pulse_trig();
      repeat (70) @(negedge clk);
      check("R8 flag set", timeout_err == 1'b1, timeout_err, 1);
      check("R8 timing", (to_rise_at - start_rise_at) == TIMEOUT_CYC, to_rise_at - start_rise_at, TIMEOUT_CYC);
      check("R8 no sample", valids == v0, valids, v0);
      check("R8 select released", adc_sel_n == 1'b1, adc_sel_n, 1);
    end
    hang = 1'b0;
    adc_idle = 1'b1;
    rise_at = ncyc;
    repeat (10) @(negedge clk);
    convert_one(12'h456);
    check("R8 recovers", valids == 7, valids, 7);
    check("R8 sticky", timeout_err == 1'b1, timeout_err, 1);

    // R9 wrap of the sample counter
    for (int i = 0; i < 252; i++) convert_one(12'((i * 37) & 12'hFFF));
    check("R9 wrap", smp_count == 8'(valids), smp_count, valids & 255);
    check("R5 queue drained", exp_q.size() == 0, exp_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule